// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt events from on-chip peripherals, from GPIO pins and from software, holds each in a pending flag, and presents a single winner to the CPU as a request line plus a 16-bit vector address. Every maskable source has a two-bit priority field. A value of zero turns the source off, and values 1, 2 and 3 are low, mid and high. When two sources share the top level, the one with the lower source index wins. A non-maskable system exception outranks all of them and is not affected by priorities, the global enable or polled mode.

Source index i maps to vector 0x0010 + 4*i. Index 0 is Timer 2 and index 1 is Timer 1. The remaining peripheral inputs come next, then the eight selectable-edge GPIO pins, then the four dual-edge GPIO pins. The exception vector is 0x0008. Vectors 0x0004 and 0x000C are never produced. GPIO pins pass through a two-flop synchronizer before edge detection. The winner is held in a register, so the presented vector follows the flags one cycle later. When the CPU pulses an acknowledge, the flag behind the presented vector is cleared. In polled mode software reads the flags on `pend_flags` and clears them itself.

Top module: `pic_vec_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `irq_req` and `irq_exc` are 0, `irq_vec` is 0x0000, and `pend_flags` and `exc_pend` are all zero. A selectable-edge pin resets to rising-edge mode. All priority fields reset to 0. Global enable and polled mode reset to off.
- R2: For selectable GPIO pin p, flag 4+p is set only on the edge that `edge_wdata` bit p selects: 1 means rising and 0 means falling. The flag reads as set after the third rising clock edge that follows the pin change. The opposite edge leaves the flag clear.
- R3: Dual-edge GPIO pin q sets flag 12+q on both rising and falling transitions.
- R4: A 1 in `sw_set` bit i sets flag i on the next clock edge. That flag then competes for the CPU exactly like a hardware-raised flag.
- R5: A 1 in `sw_clr` bit i clears flag i. If a set for bit i arrives in the same cycle, the set wins.
- R6: The priority of source i is in `prio_wdata` bits [2i+1:2i]. Among pending, enabled sources the highest value wins. A source with value 0 never raises `irq_req`, but its flag still latches.
- R7: Among pending sources at the same level, the lowest index wins. The vector presented is 0x0010 + 4*index, so Timer 2 (0x0010) beats Timer 1 (0x0014).
- R8: A `sys_exc` pulse sets `exc_pend`. One cycle later the block presents vector 0x0008 with `irq_exc` = 1. This happens ahead of any maskable source and regardless of global enable, priorities or polled mode.
- R9: With global enable off, no maskable flag raises `irq_req`. Flags still latch.
- R10: In polled mode `irq_req` stays low for all maskable flags, and the flags stay readable on `pend_flags`.
- R11: `irq_ack` sampled while `irq_req` is high clears only the flag of the vector being presented. `irq_ack` while `irq_req` is low has no effect. `irq_vec` follows a flag change one cycle later.
- R12: An edge that arrives while its flag is already set merges into that flag, so a single acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| periph_irq | input | 4 | Peripheral set strobes; bit 0 is Timer 2, bit 1 is Timer 1 |
| gpio_sel_in | input | 8 | GPIO pins with selectable edge |
| gpio_dual_in | input | 4 | GPIO pins triggering on both edges |
| sys_exc | input | 1 | System exception set strobe |
| prio_we | input | 1 | Write strobe for all priority fields |
| prio_wdata | input | 32 | Two bits per source, source i at [2i+1:2i] |
| edge_we | input | 1 | Write strobe for the edge selects |
| edge_wdata | input | 8 | Edge select per selectable pin, 1 = rising |
| ctrl_we | input | 1 | Write strobe for the global enable and polled mode |
| ctrl_gie | input | 1 | Global enable for maskable sources |
| ctrl_poll | input | 1 | Polled mode |
| sw_set | input | 16 | Software set, one bit per source |
| sw_clr | input | 16 | Software clear, one bit per source |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_req | output | 1 | Request to the CPU |
| irq_exc | output | 1 | Presented request is the system exception |
| irq_vec | output | 16 | Vector address of the winner, 0 when idle |
| pend_flags | output | 16 | Pending flags of the maskable sources |
| exc_pend | output | 1 | Pending system exception |

## Verification
The bench counts cycles from a pin change to its flag, so a synchronizer one stage short or one stage long shows up as a flag one cycle early or late. It drives the edge that a selectable pin should ignore, which catches a detector wired for the wrong polarity or for both edges. It raises equal-priority flags together, checks that the lower index is presented, and acknowledges twice in a row to show that only the presented flag clears. An arbiter scanning from the wrong end, or an acknowledge that clears every flag, fails there. It also raises an exception while maskable flags are pending with the global enable off and with polled mode on. If the exception path were gated like the others, the exception would disappear in those cases.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int unsigned VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_EXC  = 16'h0008;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0010;
  localparam int unsigned PRIO_W = 2;

  // Vector address for a registered winner; idle gives zero.
  function automatic logic [VEC_W-1:0] vec_for(input logic valid,
                                               input logic exc,
                                               input logic [VEC_W-1:0] idx);
    logic [VEC_W-1:0] v;
    if (!valid)      v = '0;
    else if (exc)    v = VEC_EXC;
    else             v = VEC_BASE + (idx << 2);
    return v;
  endfunction

endpackage

// File: rtl/pic_gpio_edge.sv
module pic_gpio_edge #(
  parameter int unsigned N_SEL  = 8,
  parameter int unsigned N_DUAL = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SEL+N_DUAL-1:0] pin_i,
  input  logic                    edge_we,
  input  logic [N_SEL-1:0]        edge_wdata,
  output logic [N_SEL+N_DUAL-1:0] pulse_o
);

  localparam int unsigned N_PIN = N_SEL + N_DUAL;

  logic [N_PIN-1:0] meta_q, meta_d;
  logic [N_PIN-1:0] sync_q, sync_d;
  logic [N_PIN-1:0] prev_q, prev_d;
  logic [N_SEL-1:0] rise_sel_q, rise_sel_d;

  // next state
  always_comb begin
    meta_d     = pin_i;
    sync_d     = meta_q;
    prev_d     = sync_q;
    rise_sel_d = rise_sel_q;
    if (edge_we) rise_sel_d = edge_wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= '0;
      sync_q     <= '0;
      prev_q     <= '0;
      rise_sel_q <= '1;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
      if (edge_we) rise_sel_q <= rise_sel_d;
    end
  end

  // edge detection: selectable polarity or both edges
  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    if (p < N_SEL) begin : g_sel
      always_comb begin
        if (rise_sel_q[p]) pulse_o[p] = sync_q[p] & ~prev_q[p];
        else               pulse_o[p] = ~sync_q[p] & prev_q[p];
      end
    end else begin : g_dual
      always_comb pulse_o[p] = sync_q[p] ^ prev_q[p];
    end
  end

endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             exc_set_i,
  input  logic             ack_i,
  input  logic             ack_exc_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N_SRC-1:0] flags_o,
  output logic             exc_o
);

  logic [N_SRC-1:0] flags_q, flags_d;
  logic [N_SRC-1:0] ack_mask;
  logic [N_SRC-1:0] clr_all;
  logic             flags_en;
  logic             exc_q, exc_d;
  logic             exc_en;

  // acknowledge mask: only the presented maskable vector
  always_comb begin
    ack_mask = '0;
    if (ack_i && !ack_exc_i) ack_mask[ack_idx_i] = 1'b1;
  end

  // next state; a set in the same cycle beats any clear
  always_comb begin
    clr_all  = clr_i | ack_mask;
    flags_d  = (flags_q & ~clr_all) | set_i;
    flags_en = (|set_i) | (|clr_all);
    exc_d    = (exc_q & ~(ack_i & ack_exc_i)) | exc_set_i;
    exc_en   = exc_set_i | (ack_i & ack_exc_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      exc_q   <= 1'b0;
    end else begin
      if (flags_en) flags_q <= flags_d;
      if (exc_en)   exc_q   <= exc_d;
    end
  end

  assign flags_o = flags_q;
  assign exc_o   = exc_q;

  // R4: every set lands, whatever else happens that cycle
  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  // R11: acknowledged exception is gone unless re-raised
  p_ack_clr_exc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && ack_exc_i && !exc_set_i) |=> !exc_q);

endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SRC-1:0]               flags_i,
  input  logic                           exc_i,
  input  logic                           prio_we,
  input  logic [N_SRC*pic_pkg::PRIO_W-1:0] prio_wdata,
  input  logic                           ctrl_we,
  input  logic                           gie_wdata,
  input  logic                           poll_wdata,
  output logic                           win_valid_o,
  output logic                           win_exc_o,
  output logic [IDX_W-1:0]               win_idx_o
);

  localparam int unsigned PW = pic_pkg::PRIO_W;

  logic [N_SRC*PW-1:0] prio_q, prio_d;
  logic                gie_q, gie_d;
  logic                poll_q, poll_d;

  logic [N_SRC-1:0]    elig;
  logic [PW-1:0]       best_lvl;
  logic [IDX_W-1:0]    best_idx;

  logic                valid_q, valid_d;
  logic                exc_q, exc_d;
  logic [IDX_W-1:0]    idx_q, idx_d;

  // configuration next state
  always_comb begin
    prio_d = prio_q;
    gie_d  = gie_q;
    poll_d = poll_q;
    if (prio_we) prio_d = prio_wdata;
    if (ctrl_we) begin
      gie_d  = gie_wdata;
      poll_d = poll_wdata;
    end
  end

  // eligibility of each maskable source
  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    always_comb elig[i] = flags_i[i] && (prio_q[i*PW +: PW] != '0)
                          && gie_q && !poll_q;
  end

  // highest level wins; scanning downward with >= favours the lower index
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (prio_q[i*PW +: PW] >= best_lvl)) begin
        best_lvl = prio_q[i*PW +: PW];
        best_idx = IDX_W'(i);
      end
    end
  end

  // winner next state: exception above everything
  always_comb begin
    valid_d = exc_i | (|elig);
    exc_d   = exc_i;
    idx_d   = exc_i ? '0 : best_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      gie_q   <= 1'b0;
      poll_q  <= 1'b0;
      valid_q <= 1'b0;
      exc_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (prio_we) prio_q <= prio_d;
      if (ctrl_we) begin
        gie_q  <= gie_d;
        poll_q <= poll_d;
      end
      valid_q <= valid_d;
      exc_q   <= exc_d;
      idx_q   <= idx_d;
    end
  end

  assign win_valid_o = valid_q;
  assign win_exc_o   = exc_q;
  assign win_idx_o   = idx_q;

  // R8: a pending exception is presented on the next cycle
  p_exc_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> (valid_q && exc_q));

  // R9: global enable off and no exception means no request
  p_gie_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !exc_i) |=> !valid_q);

endmodule

// File: rtl/pic_vec_ctrl.sv
module pic_vec_ctrl #(
  parameter int unsigned N_PERIPH = 4,
  parameter int unsigned N_SEL    = 8,
  parameter int unsigned N_DUAL   = 4,
  localparam int unsigned N_SRC   = N_PERIPH + N_SEL + N_DUAL,
  localparam int unsigned IDX_W   = $clog2(N_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_PERIPH-1:0]  periph_irq,
  input  logic [N_SEL-1:0]     gpio_sel_in,
  input  logic [N_DUAL-1:0]    gpio_dual_in,
  input  logic                 sys_exc,
  input  logic                 prio_we,
  input  logic [2*N_SRC-1:0]   prio_wdata,
  input  logic                 edge_we,
  input  logic [N_SEL-1:0]     edge_wdata,
  input  logic                 ctrl_we,
  input  logic                 ctrl_gie,
  input  logic                 ctrl_poll,
  input  logic [N_SRC-1:0]     sw_set,
  input  logic [N_SRC-1:0]     sw_clr,
  input  logic                 irq_ack,
  output logic                 irq_req,
  output logic                 irq_exc,
  output logic [15:0]          irq_vec,
  output logic [N_SRC-1:0]     pend_flags,
  output logic                 exc_pend
);

  logic                     rst_meta_q, rst_sync_q;
  logic [N_SEL+N_DUAL-1:0]  gpio_pulse;
  logic [N_SRC-1:0]         set_all;
  logic [N_SRC-1:0]         flags;
  logic                     exc_flag;
  logic                     win_valid, win_exc;
  logic [IDX_W-1:0]         win_idx;
  logic                     ack_fire;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pic_gpio_edge #(.N_SEL(N_SEL), .N_DUAL(N_DUAL)) u_gpio (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .pin_i      ({gpio_dual_in, gpio_sel_in}),
    .edge_we    (edge_we),
    .edge_wdata (edge_wdata),
    .pulse_o    (gpio_pulse)
  );

  always_comb begin
    set_all  = {gpio_pulse, periph_irq} | sw_set;
    ack_fire = irq_ack & win_valid;
  end

  pic_pend #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .set_i     (set_all),
    .clr_i     (sw_clr),
    .exc_set_i (sys_exc),
    .ack_i     (ack_fire),
    .ack_exc_i (win_exc),
    .ack_idx_i (win_idx),
    .flags_o   (flags),
    .exc_o     (exc_flag)
  );

  pic_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .flags_i     (flags),
    .exc_i       (exc_flag),
    .prio_we     (prio_we),
    .prio_wdata  (prio_wdata),
    .ctrl_we     (ctrl_we),
    .gie_wdata   (ctrl_gie),
    .poll_wdata  (ctrl_poll),
    .win_valid_o (win_valid),
    .win_exc_o   (win_exc),
    .win_idx_o   (win_idx)
  );

  always_comb begin
    irq_req    = win_valid;
    irq_exc    = win_valid & win_exc;
    irq_vec    = pic_pkg::vec_for(win_valid, win_exc, 16'(win_idx));
    pend_flags = flags;
    exc_pend   = exc_flag;
  end

  // R7: a presented vector is word aligned and never reset or reserved
  p_vec_legal_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_req |-> (irq_vec[1:0] == 2'b00 && irq_vec >= 16'h0008
                 && irq_vec != 16'h000C));

endmodule

// File: tb/pic_vec_ctrl_tb.sv
module pic_vec_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  periph_irq;
  logic [7:0]  gpio_sel_in;
  logic [3:0]  gpio_dual_in;
  logic        sys_exc;
  logic        prio_we;
  logic [31:0] prio_wdata;
  logic        edge_we;
  logic [7:0]  edge_wdata;
  logic        ctrl_we, ctrl_gie, ctrl_poll;
  logic [15:0] sw_set, sw_clr;
  logic        irq_ack;
  logic        irq_req, irq_exc;
  logic [15:0] irq_vec;
  logic [15:0] pend_flags;
  logic        exc_pend;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pic_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq),
    .gpio_sel_in(gpio_sel_in), .gpio_dual_in(gpio_dual_in),
    .sys_exc(sys_exc), .prio_we(prio_we), .prio_wdata(prio_wdata),
    .edge_we(edge_we), .edge_wdata(edge_wdata), .ctrl_we(ctrl_we),
    .ctrl_gie(ctrl_gie), .ctrl_poll(ctrl_poll), .sw_set(sw_set),
    .sw_clr(sw_clr), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_exc(irq_exc), .irq_vec(irq_vec), .pend_flags(pend_flags),
    .exc_pend(exc_pend)
  );

  // {prio[31:0], set mask[15:0], gie, expected req, expected vector[15:0]}
  localparam logic [65:0] TBL [7] = '{
    {32'h55555555, 16'h0003, 1'b1, 1'b1, 16'h0010},
    {32'h5555555D, 16'h0003, 1'b1, 1'b1, 16'h0014},
    {32'hAAAAAAAA, 16'h8000, 1'b1, 1'b1, 16'h004C},
    {32'h55555554, 16'h0001, 1'b1, 1'b0, 16'h0000},
    {32'h55655555, 16'h0C01, 1'b1, 1'b1, 16'h0038},
    {32'hFFFFFFFF, 16'h00F0, 1'b0, 1'b0, 16'h0000},
    {32'hFFFFFFFF, 16'h00F0, 1'b1, 1'b1, 16'h0020}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sset(input logic [15:0] m);
    sw_set = m; tick(1); sw_set = '0;
  endtask

  task automatic sclr(input logic [15:0] m);
    sw_clr = m; tick(1); sw_clr = '0;
  endtask

  task automatic wprio(input logic [31:0] v);
    prio_we = 1'b1; prio_wdata = v; tick(1); prio_we = 1'b0;
  endtask

  task automatic wctrl(input logic g, input logic p);
    ctrl_we = 1'b1; ctrl_gie = g; ctrl_poll = p; tick(1); ctrl_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; periph_irq = '0; gpio_sel_in = '0; gpio_dual_in = '0;
    sys_exc = 1'b0; prio_we = 1'b0; prio_wdata = '0; edge_we = 1'b0;
    edge_wdata = '0; ctrl_we = 1'b0; ctrl_gie = 1'b0; ctrl_poll = 1'b0;
    sw_set = '0; sw_clr = '0; irq_ack = 1'b0;
    tick(3);
    chk("R1 req in reset", 32'(irq_req), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 req after reset", 32'(irq_req), 0);
    chk("R1 vec after reset", 32'(irq_vec), 0);
    chk("R1 flags after reset", 32'(pend_flags), 0);
    chk("R1 exc after reset", 32'(exc_pend), 0);

    // table of arbitration cases (R6 R7 R9 R4)
    for (int k = 0; k < 7; k++) begin
      sclr(16'hFFFF);
      wprio(TBL[k][65:34]);
      wctrl(TBL[k][17], 1'b0);
      sset(TBL[k][33:18]);
      chk("R4 sw flags latched", 32'(pend_flags), 32'(TBL[k][33:18]));
      tick(1);
      chk("R6 R9 table req", 32'(irq_req), 32'(TBL[k][16]));
      chk("R7 table vec", 32'(irq_vec), 32'(TBL[k][15:0]));
    end

    // R8: exception over pending maskable with global enable off
    sclr(16'hFFFF);
    wprio(32'hFFFFFFFF);
    wctrl(1'b0, 1'b0);
    sset(16'h0001);
    sys_exc = 1'b1; tick(1); sys_exc = 1'b0;
    chk("R8 exc latched", 32'(exc_pend), 1);
    tick(1);
    chk("R8 exc flag out", 32'(irq_exc), 1);
    chk("R8 exc vector", 32'(irq_vec), 32'h8);
    wctrl(1'b1, 1'b0);
    tick(1);
    chk("R8 exc beats enabled source", 32'(irq_vec), 32'h8);
    ack();
    chk("R11 exc cleared by ack", 32'(exc_pend), 0);
    chk("R11 ack left maskable", 32'(pend_flags), 32'h1);
    tick(1);
    chk("R8 maskable after exc", 32'(irq_vec), 32'h10);
    chk("R8 exc flag drops", 32'(irq_exc), 0);

    // R11: ack clears only the presented flag
    sset(16'h0002);
    tick(1);
    ack();
    chk("R11 only presented cleared", 32'(pend_flags), 32'h2);
    tick(1);
    chk("R11 next vector", 32'(irq_vec), 32'h14);
    wctrl(1'b0, 1'b0);
    tick(1);
    chk("R9 gie off blocks", 32'(irq_req), 0);
    ack();
    chk("R11 idle ack ignored", 32'(pend_flags), 32'h2);

    // R10: polled mode
    wctrl(1'b1, 1'b1);
    tick(1);
    chk("R10 polled req low", 32'(irq_req), 0);
    chk("R10 polled flags visible", 32'(pend_flags), 32'h2);
    sys_exc = 1'b1; tick(1); sys_exc = 1'b0;
    tick(1);
    chk("R8 exc in polled mode", 32'(irq_vec), 32'h8);
    ack();
    tick(1);
    chk("R10 polled after exc", 32'(irq_req), 0);
    wctrl(1'b1, 1'b0);
    tick(1);
    chk("R10 leaving polled", 32'(irq_vec), 32'h14);

    // R5: set beats clear in same cycle, clear alone works
    sw_set = 16'h0008; sw_clr = 16'h0008; tick(1); sw_set = '0; sw_clr = '0;
    chk("R5 set wins", 32'(pend_flags[3]), 1);
    sclr(16'h0008);
    chk("R5 clear", 32'(pend_flags[3]), 0);
    sclr(16'hFFFF);
    wprio(32'h0);

    // R2: selectable edge pin 0 -> source 4, default rising
    gpio_sel_in[0] = 1'b1;
    tick(2);
    chk("R2 not yet after two edges", 32'(pend_flags[4]), 0);
    tick(1);
    chk("R2 rising sets on third edge", 32'(pend_flags[4]), 1);
    sclr(16'h0010);
    gpio_sel_in[0] = 1'b0;
    tick(5);
    chk("R2 falling ignored in rising mode", 32'(pend_flags[4]), 0);
    edge_we = 1'b1; edge_wdata = 8'hFE; tick(1); edge_we = 1'b0;
    gpio_sel_in[0] = 1'b1;
    tick(5);
    chk("R2 rising ignored in falling mode", 32'(pend_flags[4]), 0);
    gpio_sel_in[0] = 1'b0;
    tick(5);
    chk("R2 falling sets", 32'(pend_flags[4]), 1);
    sclr(16'h0010);

    // R3: dual-edge pin 0 -> source 12
    gpio_dual_in[0] = 1'b1;
    tick(3);
    chk("R3 rise sets", 32'(pend_flags[12]), 1);
    sclr(16'h1000);
    gpio_dual_in[0] = 1'b0;
    tick(3);
    chk("R3 fall sets", 32'(pend_flags[12]), 1);

    // R12: further edges merge, one ack clears
    gpio_dual_in[0] = 1'b1; tick(4);
    gpio_dual_in[0] = 1'b0; tick(4);
    wprio(32'h01000000);
    tick(1);
    chk("R12 merged vector", 32'(irq_vec), 32'h40);
    ack();
    chk("R12 single ack clears", 32'(pend_flags), 0);
    tick(1);
    chk("R12 no leftover request", 32'(irq_req), 0);

    // R1: reset in the middle of activity
    sset(16'h0001);
    tick(1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset req", 32'(irq_req), 0);
    chk("R1 async reset flags", 32'(pend_flags), 0);
    tick(2);
    rst_n = 1'b1;
    tick(4);
    chk("R1 prio cleared by reset", 32'(irq_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule